// File: doc/BRIEF.md
# Self-Voting Triplicated Payload Scrambler

This block scrambles the payload of a radiation-tolerant optical link transmitter. Each frame clock it may accept one 96-bit payload word and return the scrambled word one clock later. The scrambler is multiplicative and self-synchronizing, with taps at 39 and 58 bits back. The word is processed in one clock as 96 successive bits, most significant bit first. Because the receiver rebuilds its state from the scrambled stream alone, neither end needs a reset that the other end shares.

The 58-bit history register has no reset. It is held in three copies. Every flip-flop of every copy is loaded through a majority vote over the three copies' next-state values, so an upset in one copy is outvoted at the very next edge and never stays latched. Upset-injection inputs let a test flip one bit of one copy for one cycle. A matching descrambler module is provided so that a receiver can be checked against the transmitter.

Top module: `selfVotingScrambler`

## Requirements
- R1: For payload bit d (taken from bit 95 down to bit 0 of the word), the scrambled bit is s = d XOR s39 XOR s58, where sN is the scrambled bit N positions earlier in the stream; the stream continues across words, and scrWord bit k carries the scrambled value of payload bit k.
- R2: A word presented with inValid high at a clock edge appears on scrWord after that edge, with outValid high for that one cycle; outValid is low after any edge with inValid low and while rstN is low.
- R3: After an edge with inValid low, scrWord holds its previous value and the scrambler history does not advance, so the next valid word continues the stream as if the idle cycles were absent.
- R4: rstN does not touch the scrambler history: a reset pulse between words does not restart the scrambled sequence.
- R5: With injEn high, injCopy 0, 1 or 2 selects a history copy and injBit 0..57 selects the bit position (0 = most recent scrambled bit) that is inverted in that copy at that edge; scrWord stays equal to the upset-free stream, and the copy agrees with the other two again after the next edge.
- R6: An upset injected at the same edge as a valid word, or upsets into different copies at consecutive edges, leave scrWord equal to the upset-free stream.
- R7: injCopy value 3, or injBit values 58 to 63, inject nothing.
- R8: The descrambler returns the original payload one clock after each scrambled word it receives, starting with the second valid word after power-up, whatever its initial history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame clock |
| rstN | input | 1 | Active-low reset of the valid flag only |
| inValid | input | 1 | Payload word present this cycle |
| payload | input | 96 | Payload word, bit 95 scrambled first |
| injEn | input | 1 | Upset-injection enable |
| injCopy | input | 2 | History copy to upset (0..2; 3 selects none) |
| injBit | input | 6 | History bit to invert (0..57) |
| outValid | output | 1 | scrWord carries a newly scrambled word |
| scrWord | output | 96 | Scrambled word |

## Verification
The two functions that can fall in the same cycle are the normal advance of the history by a valid word and the inversion of a history bit by the injection port. The bench provokes this by raising injEn at the same edge as inValid, sweeping every copy and the lowest, middle and highest bit positions, and by upsetting different copies on consecutive edges. It judges the result with a behavioural bit-queue model of the stream: scrWord must match that model on every valid cycle and hold on every idle one, and the descrambler fed from the outputs must return the payload.

// File: rtl/scramPkg.sv
package scramPkg;
  localparam int WORD_W   = 96;
  localparam int STATE_W  = 58;
  localparam int TAP_NEAR = 39;
  localparam int COPIES   = 3;
  localparam int IDX_W    = $clog2(STATE_W);
  localparam int SEL_W    = $clog2(COPIES + 1);

  typedef struct packed {
    logic              advance;
    logic [COPIES-1:0] injHit;
    logic [IDX_W-1:0]  injIdx;
  } scramStrobes_t;
endpackage

// File: rtl/scramControl.sv
module scramControl
  import scramPkg::*;
#(
  parameter int Copies = COPIES,
  parameter int SelW   = SEL_W,
  parameter int IdxW   = IDX_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            injEn,
  input  logic [SelW-1:0] injCopy,
  input  logic [IdxW-1:0] injBit,
  output scramStrobes_t   strb,
  output logic            outValid
);
  always_comb begin
    strb.advance = inValid;
    strb.injIdx  = injBit;
    for (int c = 0; c < Copies; c++) begin
      strb.injHit[c] = injEn && (injCopy == SelW'(c));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R5 / R7: at most one copy is targeted by an upset at any edge
  assert_single_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.injHit));
endmodule

// File: rtl/scramDatapath.sv
module scramDatapath
  import scramPkg::*;
#(
  parameter int WordW   = WORD_W,
  parameter int StateW  = STATE_W,
  parameter int TapNear = TAP_NEAR,
  parameter int IdxW    = IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  scramStrobes_t    strb,
  input  logic [WordW-1:0] payload,
  output logic [WordW-1:0] scrWord
);
  localparam int SeqW = WordW + StateW;

  // Bit-serial scrambling of one word; seq[k] is the stream bit at word
  // position k, older bits sit at higher indices, the history above the word.
  function automatic logic [SeqW-1:0] scramStep(input logic [StateW-1:0] hist,
                                                input logic [WordW-1:0]  din);
    logic [SeqW-1:0] seq;
    seq = '0;
    seq[WordW +: StateW] = hist;
    for (int k = WordW - 1; k >= 0; k--) begin
      seq[k] = din[k] ^ seq[k + TapNear] ^ seq[k + StateW];
    end
    return seq;
  endfunction

  logic [StateW-1:0] copyState [3];
  logic [StateW-1:0] candState [3];
  logic [WordW-1:0]  candWord  [3];
  logic [StateW-1:0] votedState;
  logic [WordW-1:0]  votedWord;

  for (genvar c = 0; c < 3; c++) begin : gCopy
    logic [SeqW-1:0]   stepSeq;
    logic [StateW-1:0] upsetMask;
    always_comb begin
      stepSeq      = scramStep(copyState[c], payload);
      candWord[c]  = stepSeq[WordW-1:0];
      candState[c] = strb.advance ? stepSeq[StateW-1:0] : copyState[c];
      upsetMask    = strb.injHit[c] ? (StateW'(1) << strb.injIdx) : '0;
    end
    // every flip-flop of every copy loads the majority of the three copies
    always_ff @(posedge clk) begin
      copyState[c] <= votedState ^ upsetMask;
    end
  end

  always_comb begin
    votedState = (candState[0] & candState[1]) | (candState[0] & candState[2])
               | (candState[1] & candState[2]);
    votedWord  = (candWord[0] & candWord[1]) | (candWord[0] & candWord[2])
               | (candWord[1] & candWord[2]);
  end

  always_ff @(posedge clk) begin
    if (strb.advance) scrWord <= votedWord;
  end

  // R5: without an upset at an edge, all copies agree after it
  assert_copies_agree_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(|strb.injHit) |=> (copyState[0] == copyState[1]) && (copyState[1] == copyState[2]));

  // R6: an upset leaves a majority of copies in agreement
  assert_upset_confined_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.injHit) |=> (copyState[0] == copyState[1]) || (copyState[0] == copyState[2])
                    || (copyState[1] == copyState[2]));

  // R3: idle cycles keep the scrambled word
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(scrWord));

  // R3: idle cycles without upset keep the agreed history
  assert_history_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !(|strb.injHit) && (copyState[0] == copyState[1])
     && (copyState[1] == copyState[2])) |=> $stable(copyState[0]));
endmodule

// File: rtl/scramDescrambler.sv
module scramDescrambler
  import scramPkg::*;
#(
  parameter int WordW   = WORD_W,
  parameter int StateW  = STATE_W,
  parameter int TapNear = TAP_NEAR
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [WordW-1:0] rxWord,
  output logic             plainValid,
  output logic [WordW-1:0] plainWord
);
  localparam int SeqW = WordW + StateW;

  logic [StateW-1:0] rxHist;
  logic [SeqW-1:0]   rxSeq;
  logic [WordW-1:0]  decoded;

  always_comb begin
    rxSeq = {rxHist, rxWord};
    for (int k = 0; k < WordW; k++) begin
      decoded[k] = rxSeq[k] ^ rxSeq[k + TapNear] ^ rxSeq[k + StateW];
    end
  end

  always_ff @(posedge clk) begin
    if (rxValid) begin
      rxHist    <= rxWord[StateW-1:0];
      plainWord <= decoded;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) plainValid <= 1'b0;
    else       plainValid <= rxValid;
  end

  // R8: output word holds between received words
  assert_plain_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(plainWord));
endmodule

// File: rtl/selfVotingScrambler.sv
module selfVotingScrambler
  import scramPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] payload,
  input  logic              injEn,
  input  logic [SEL_W-1:0]  injCopy,
  input  logic [IDX_W-1:0]  injBit,
  output logic              outValid,
  output logic [WORD_W-1:0] scrWord
);
  scramStrobes_t strb;

  scramControl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .injEn(injEn),
    .injCopy(injCopy), .injBit(injBit), .strb(strb), .outValid(outValid)
  );

  scramDatapath uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .payload(payload), .scrWord(scrWord)
  );
endmodule

// File: tb/tb_selfVotingScrambler.sv
`timescale 1ns/1ps
module tb_selfVotingScrambler;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [95:0] payload = '0;
  logic        injEn = 1'b0;
  logic [1:0]  injCopy = '0;
  logic [5:0]  injBit = '0;
  logic        outValid;
  logic [95:0] scrWord;
  logic        plainValid;
  logic [95:0] plainWord;

  always #10 clk = ~clk;

  selfVotingScrambler dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .payload(payload), .injEn(injEn),
    .injCopy(injCopy), .injBit(injBit), .outValid(outValid), .scrWord(scrWord)
  );

  scramDescrambler dsc (
    .clk(clk), .rstN(rstN), .rxValid(outValid), .rxWord(scrWord),
    .plainValid(plainValid), .plainWord(plainWord)
  );

  int  checks = 0;
  int  fails = 0;
  bit  done = 0;
  bit  hist[$];
  bit  synced = 0;
  logic [95:0] lastWord = '0;
  logic [95:0] lastPayload = '0;
  bit  lastValid = 0;
  int  rxSeen = 0;

  function automatic void chk(input bit ok, input string req, input logic [95:0] act,
                              input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  function automatic logic [95:0] modelScram(input logic [95:0] d);
    logic [95:0] w;
    for (int k = 95; k >= 0; k--) begin
      bit b;
      b = d[k] ^ hist[38] ^ hist[57];
      w[k] = b;
      hist.push_front(b);
      void'(hist.pop_back());
    end
    return w;
  endfunction

  task automatic step(input bit v, input logic [95:0] d, input bit ie, input int cp,
                      input int bi, input string req);
    bit rstNow;
    logic [95:0] exp;
    inValid = v; payload = d; injEn = ie; injCopy = cp[1:0]; injBit = bi[5:0];
    rstNow = rstN;
    @(negedge clk);
    chk(outValid == (v && rstNow), "R2 outValid", 96'(outValid), 96'(v && rstNow));
    if (v) begin
      if (!synced) begin
        hist = {};
        for (int i = 0; i < 58; i++) hist.push_back(scrWord[i]);
        synced = 1;
      end else begin
        exp = modelScram(d);
        chk(scrWord == exp, req, scrWord, exp);
      end
    end else if (synced) begin
      chk(scrWord == lastWord, "R3 idle hold", scrWord, lastWord);
    end
    chk(plainValid == (lastValid && rstNow), "R8 plainValid", 96'(plainValid),
        96'(lastValid && rstNow));
    if (lastValid && rstNow) begin
      rxSeen++;
      if (rxSeen >= 2) chk(plainWord == lastPayload, "R8 descrambled", plainWord, lastPayload);
    end
    lastValid = outValid;
    lastPayload = d;
    lastWord = scrWord;
  endtask

  function automatic logic [95:0] rnd96();
    return {$urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < 3; i++) step(0, '0, 0, 0, 0, "R2 reset");
    rstN = 1'b1;
    step(0, '0, 0, 0, 0, "R2 idle");
    // first word synchronises the model from the observable history
    step(1, rnd96(), 0, 0, 0, "R1 sync");
    for (int i = 0; i < 20; i++) step(1, rnd96(), 0, 0, 0, "R1 random");
    step(1, '0, 0, 0, 0, "R1 zeros");
    step(1, '1, 0, 0, 0, "R1 ones");
    step(1, {24{4'hA}}, 0, 0, 0, "R1 alternating");
    step(1, 96'h1, 0, 0, 0, "R1 single lsb");
    step(1, 96'h8 << 92, 0, 0, 0, "R1 single msb");
    // R3 idle gaps
    for (int i = 0; i < 3; i++) step(0, rnd96(), 0, 0, 0, "R3 idle");
    step(1, rnd96(), 0, 0, 0, "R3 continue after idle");
    step(1, rnd96(), 0, 0, 0, "R3 continue after idle");
    step(0, '0, 0, 0, 0, "R3 idle");
    // R4 reset pulse does not restart the sequence
    rstN = 1'b0;
    step(0, '0, 0, 0, 0, "R4 in reset");
    step(0, '0, 0, 0, 0, "R4 in reset");
    rstN = 1'b1;
    step(0, '0, 0, 0, 0, "R4 idle");
    for (int i = 0; i < 3; i++) step(1, rnd96(), 0, 0, 0, "R4 after reset");
    // R5 upsets on idle cycles, then words
    for (int c = 0; c < 3; c++) begin
      for (int b = 0; b < 58; b += 28) begin
        step(0, '0, 1, c, b, "R5 upset idle");
        step(1, rnd96(), 0, 0, 0, "R5 word after upset");
        step(0, '0, 1, c, 57, "R5 upset msb idle");
        step(1, rnd96(), 0, 0, 0, "R5 word after upset");
      end
    end
    // R6 upsets in the same cycle as a word
    for (int c = 0; c < 3; c++) begin
      step(1, rnd96(), 1, c, 0, "R6 upset with word");
      step(1, rnd96(), 1, c, 38, "R6 upset with word");
      step(1, rnd96(), 1, c, 57, "R6 upset with word");
      step(1, rnd96(), 0, 0, 0, "R6 word after");
    end
    // R6 consecutive upsets into different copies
    step(1, rnd96(), 1, 0, 12, "R6 consecutive copy0");
    step(1, rnd96(), 1, 1, 12, "R6 consecutive copy1");
    step(1, rnd96(), 1, 2, 12, "R6 consecutive copy2");
    step(0, '0, 1, 0, 5, "R6 consecutive idle");
    step(0, '0, 1, 1, 5, "R6 consecutive idle");
    step(1, rnd96(), 0, 0, 0, "R6 word after");
    // R7 unused selector codes inject nothing
    step(1, rnd96(), 1, 3, 10, "R7 copy code 3");
    step(1, rnd96(), 1, 0, 60, "R7 bit 60");
    step(0, '0, 1, 1, 63, "R7 bit 63 idle");
    step(1, rnd96(), 0, 0, 0, "R7 word after");
    for (int i = 0; i < 8; i++) step(1, rnd96(), 0, 0, 0, "R1 tail");
    step(0, '0, 0, 0, 0, "R8 flush");
    step(0, '0, 0, 0, 0, "R8 flush");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule